// File: doc/BRIEF.md
# Video Port Pixel Output Formatter

This block takes internal ARGB pixels, 12 bits per channel, and drives them onto a parallel video data port of up to 24 lines. The active port width is chosen from 24, 16 or 8 lines. A narrower source pixel that was widened by bit replication comes back out exactly, bit for bit. This lets the port carry arbitrary non-video payload, such as a memory image, without altering it.

Pixels arrive on a valid/ready handshake. Each accepted pixel produces one or more output beats, marked by a data-enable strobe.

In direct mode every pixel takes one beat. In time-division mode the 24-bit RGB word is sent over several consecutive beats. The number of beats and the number of bits in each beat are both programmable. The configuration inputs are sampled only when a pixel is accepted, so a multi-beat sequence always finishes under the settings it started with.

Top module: `vp_pixel_formatter`

## Requirements
- R1: While reset is held and right after it, `out_de` is 0, `out_data` is 0 and `in_ready` is 1.
- R2: In direct mode with width code 0 (24 lines) or 3 (treated as 24 lines), the beat after acceptance carries R[11:4] on lines [23:16], G[11:4] on [15:8] and B[11:4] on [7:0]. Alpha is not output.
- R3: In direct mode with width code 1 (16 lines), lines [15:0] carry {R[11:7], G[11:6], B[11:7]} and lines [23:16] are 0. A 5-6-5 word widened as R={r,r,r[4:3]}, G={g,g}, B={b,b,b[4:3]} comes back out unchanged.
- R4: In direct mode with width code 2 (8 lines), only lines [7:0] are driven, carrying B[11:4]. Lines [23:8] are 0.
- R5: With time-division enabled, cycle code c gives min(c+1, 3) beats. The bits are taken from the 24-bit word {R[11:4], G[11:4], B[11:4]}, most significant first. Beat k carries the next n_k bits, right-aligned on the lowest lines, where n_k is bits field k of `cfg_slot_bits` (bits [5k+4:5k]). A count of 0 gives a zero beat and consumes nothing. With code 2 and counts 8/8/8 the beats are the R, G and B bytes.
- R6: In time-division mode, lines above the active width are forced to 0. A bit count above 24 acts as 24.
- R7: After a multi-beat pixel is accepted, `in_ready` is 0 until the beat that carries the last slice, and it is 1 during that beat. A pixel offered while `in_ready` is 0 is not taken and does not disturb the beats in progress.
- R8: `out_de` is 1 in every beat that carries pixel data, and 0 in any cycle that follows one with no acceptance and no pending slice.
- R9: Configuration changes made after acceptance have no effect on the remaining beats of that pixel.
- R10: With `in_valid` held high, consecutive time-division pixels follow with no idle beat between them.
- R11: With time-division off, each accepted pixel yields exactly one beat and `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Pixel can be accepted this cycle |
| in_pixel | input | 48 | {A, R, G, B}, 12 bits each, A most significant |
| cfg_width | input | 2 | Active lines: 0=24, 1=16, 2=8, 3=24 |
| cfg_tdm_en | input | 1 | Enables time-division output |
| cfg_cyc_code | input | 2 | Beats per pixel minus one (clamped to 3 beats) |
| cfg_slot_bits | input | 15 | Three 5-bit per-beat bit counts, beat 1 in the low field |
| out_data | output | 24 | Parallel port data |
| out_de | output | 1 | Data enable |

## Verification
The bench targets the boundaries of the time-division sequence. A design that raised `in_ready` one beat early would drop or mix the last slice. One that kept it low a beat too long would leave a gap between back-to-back pixels.

Uneven and zero bit counts, and counts above the port width, are driven to expose a mis-sized shift. A wrong shift shows up as bytes slid out of position or as stray high lines. Configuration is changed in the middle of a sequence; a design that read it live would switch formats partway through a pixel. The 5-6-5 round trip catches a design that takes the wrong channel bits in 16-line mode, because a single misplaced bit breaks exact recovery.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
   localparam int PORT_W = 24;

   typedef enum logic [1:0] {
      WID_24  = 2'd0,
      WID_16  = 2'd1,
      WID_8   = 2'd2,
      WID_24B = 2'd3
   } vpf_width_e;

   function automatic logic [PORT_W-1:0] line_mask(input logic [1:0] w);
      case (vpf_width_e'(w))
         WID_16:  line_mask = {{(PORT_W-16){1'b0}}, {16{1'b1}}};
         WID_8:   line_mask = {{(PORT_W-8){1'b0}}, {8{1'b1}}};
         default: line_mask = {PORT_W{1'b1}};
      endcase
   endfunction
endpackage

// File: rtl/vpf_pack.sv
module vpf_pack #(
   parameter int CH_W = 12
) (
   input  logic [4*CH_W-1:0] pixel,
   output logic [23:0]       rgb888,
   output logic [15:0]       rgb565
);
   localparam int R_HI = 3*CH_W - 1;
   localparam int G_HI = 2*CH_W - 1;
   localparam int B_HI = CH_W - 1;

   generate
      if (CH_W < 8) begin : g_bad_ch
         $error("vpf_pack: CH_W must be at least 8");
      end
   endgenerate

   assign rgb888 = {pixel[R_HI -: 8], pixel[G_HI -: 8], pixel[B_HI -: 8]};
   assign rgb565 = {pixel[R_HI -: 5], pixel[G_HI -: 6], pixel[B_HI -: 5]};

   logic unused_low;
   assign unused_low = ^{pixel[4*CH_W-1:3*CH_W], pixel[R_HI-8:2*CH_W],
                         pixel[G_HI-8:CH_W], pixel[B_HI-8:0]};
endmodule

// File: rtl/vpf_slot_pick.sv
module vpf_slot_pick #(
   parameter int PORT_W = 24,
   parameter int BITS_W = 5
) (
   input  logic [PORT_W-1:0] word,
   input  logic [BITS_W-1:0] nbits,
   output logic [PORT_W-1:0] field,
   output logic [PORT_W-1:0] rest
);
   generate
      if ((1 << BITS_W) <= PORT_W) begin : g_bad_bits
         $error("vpf_slot_pick: BITS_W too narrow for PORT_W");
      end
   endgenerate

   int n;
   always_comb begin
      n = int'(nbits);
      if (n > PORT_W) n = PORT_W;
      if (n == 0) begin
         field = '0;
         rest  = word;
      end else begin
         field = word >> (PORT_W - n);
         rest  = (n == PORT_W) ? '0 : (word << n);
      end
   end
endmodule

// File: rtl/vpf_seq.sv
module vpf_seq #(
   parameter int NUM_SLOTS = 3,
   parameter int IDX_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             tdm_en,
   input  logic [IDX_W-1:0] cyc_code,
   output logic             busy,
   output logic             ready,
   output logic [IDX_W-1:0] slot_idx
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

   logic [IDX_W-1:0] left_q, first_left;

   always_comb begin
      if (int'(cyc_code) >= NUM_SLOTS - 1) first_left = LAST;
      else                                 first_left = cyc_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_q   <= '0;
         slot_idx <= '0;
      end else if (accept) begin
         left_q   <= tdm_en ? first_left : '0;
         slot_idx <= IDX_W'(1);
      end else if (left_q != '0) begin
         left_q   <= left_q - 1'b1;
         slot_idx <= slot_idx + 1'b1;
      end
   end

   assign busy  = (left_q != '0);
   assign ready = !busy;
endmodule

// File: rtl/vp_pixel_formatter.sv
module vp_pixel_formatter #(
   parameter int CH_W      = 12,
   parameter int NUM_SLOTS = 3,
   parameter int BITS_W    = 5,
   localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int PIX_W    = 4 * CH_W,
   localparam int PORT_W   = vpf_pkg::PORT_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   output logic                        in_ready,
   input  logic [PIX_W-1:0]            in_pixel,
   input  logic [1:0]                  cfg_width,
   input  logic                        cfg_tdm_en,
   input  logic [IDX_W-1:0]            cfg_cyc_code,
   input  logic [NUM_SLOTS*BITS_W-1:0] cfg_slot_bits,
   output logic [PORT_W-1:0]           out_data,
   output logic                        out_de
);
   import vpf_pkg::*;

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("vp_pixel_formatter: NUM_SLOTS must be at least 2");
      end
   endgenerate

   logic [23:0] rgb888;
   logic [15:0] rgb565;
   logic        accept, busy;
   logic [IDX_W-1:0] slot_idx;

   logic [PORT_W-1:0]           sreg_q;
   logic [1:0]                  wid_q;
   logic [NUM_SLOTS*BITS_W-1:0] bits_q;

   logic [PORT_W-1:0] first_field, first_rest, next_field, next_rest, direct_word;
   logic [BITS_W-1:0] next_bits;

   vpf_pack #(.CH_W(CH_W)) u_pack (
      .pixel  (in_pixel),
      .rgb888 (rgb888),
      .rgb565 (rgb565)
   );

   vpf_seq #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .tdm_en   (cfg_tdm_en),
      .cyc_code (cfg_cyc_code),
      .busy     (busy),
      .ready    (in_ready),
      .slot_idx (slot_idx)
   );

   assign accept    = in_valid && in_ready;
   assign next_bits = bits_q[slot_idx*BITS_W +: BITS_W];

   vpf_slot_pick #(.PORT_W(PORT_W), .BITS_W(BITS_W)) u_first (
      .word  (PORT_W'(rgb888)),
      .nbits (cfg_slot_bits[BITS_W-1:0]),
      .field (first_field),
      .rest  (first_rest)
   );

   vpf_slot_pick #(.PORT_W(PORT_W), .BITS_W(BITS_W)) u_next (
      .word  (sreg_q),
      .nbits (next_bits),
      .field (next_field),
      .rest  (next_rest)
   );

   always_comb begin
      case (vpf_width_e'(cfg_width))
         WID_16:  direct_word = PORT_W'(rgb565);
         WID_8:   direct_word = PORT_W'(rgb888[7:0]);
         default: direct_word = PORT_W'(rgb888);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data <= '0;
         out_de   <= 1'b0;
         sreg_q   <= '0;
         wid_q    <= '0;
         bits_q   <= '0;
      end else if (accept) begin
         out_de <= 1'b1;
         wid_q  <= cfg_width;
         bits_q <= cfg_slot_bits;
         sreg_q <= first_rest;
         if (cfg_tdm_en) out_data <= first_field & line_mask(cfg_width);
         else            out_data <= direct_word;
      end else if (busy) begin
         out_de   <= 1'b1;
         out_data <= next_field & line_mask(wid_q);
         sreg_q   <= next_rest;
      end else begin
         out_de <= 1'b0;
      end
   end
endmodule

// File: rtl/vpf_checker.sv
module vpf_checker #(
   parameter int CH_W  = 12,
   parameter int IDX_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [4*CH_W-1:0]  in_pixel,
   input logic [1:0]         cfg_width,
   input logic               cfg_tdm_en,
   input logic [IDX_W-1:0]   cfg_cyc_code,
   input logic [23:0]        out_data,
   input logic               out_de
);
   logic acc;
   assign acc = in_valid && in_ready;

   a_r2_direct24: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cfg_tdm_en && cfg_width == 2'd0) |=>
      out_data == {$past(in_pixel[3*CH_W-1 -: 8]), $past(in_pixel[2*CH_W-1 -: 8]),
                   $past(in_pixel[CH_W-1 -: 8])});

   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cfg_tdm_en && cfg_width == 2'd1) |=> out_data[23:16] == 8'h00);

   a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cfg_tdm_en && cfg_cyc_code != '0) |=> !in_ready);

   a_r8_de_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_de);

   a_r8_idle_no_de: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && !in_valid) |=> !out_de);

   a_r11_direct_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cfg_tdm_en) |=> in_ready);
endmodule

bind vp_pixel_formatter vpf_checker #(.CH_W(CH_W), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .in_pixel     (in_pixel),
   .cfg_width    (cfg_width),
   .cfg_tdm_en   (cfg_tdm_en),
   .cfg_cyc_code (cfg_cyc_code),
   .out_data     (out_data),
   .out_de       (out_de)
);

// File: tb/sim_vp_pixel_formatter.sv
module sim_vp_pixel_formatter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [47:0] in_pixel = '0;
   logic [1:0]  cfg_width = 2'd0;
   logic        cfg_tdm_en = 1'b0;
   logic [1:0]  cfg_cyc_code = 2'd0;
   logic [14:0] cfg_slot_bits = '0;
   logic [23:0] out_data;
   logic        out_de;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   vp_pixel_formatter u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_pixel(in_pixel), .cfg_width(cfg_width), .cfg_tdm_en(cfg_tdm_en),
      .cfg_cyc_code(cfg_cyc_code), .cfg_slot_bits(cfg_slot_bits),
      .out_data(out_data), .out_de(out_de));

   function automatic logic [47:0] mkpix(logic [11:0] r, logic [11:0] g, logic [11:0] b);
      return {12'hFFF, r, g, b};
   endfunction

   function automatic logic [23:0] word888(logic [47:0] p);
      return {p[35:28], p[23:16], p[11:4]};
   endfunction

   function automatic logic [14:0] bits3(int a, int b, int c);
      return {5'(c), 5'(b), 5'(a)};
   endfunction

   task automatic check(string req, logic [23:0] act, logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic offer(logic [47:0] p);
      @(negedge clk);
      in_pixel = p;
      in_valid = 1'b1;
      check("R7 ready before offer", 24'(in_ready), 24'd1);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 de", 24'(out_de), 24'd0);
      check("R1 data", out_data, 24'h0);
      check("R1 ready", 24'(in_ready), 24'd1);
   endtask

   task automatic t_direct;
      logic [47:0] p;
      p = mkpix(12'hABC, 12'h5D3, 12'h7E1);
      cfg_tdm_en = 1'b0;
      cfg_width = 2'd0;
      offer(p);
      check("R2 24 lines", out_data, 24'hAB5D7E);
      check("R8 de", 24'(out_de), 24'd1);
      check("R11 ready", 24'(in_ready), 24'd1);
      cfg_width = 2'd3;
      offer(p);
      check("R2 code3", out_data, 24'hAB5D7E);
      cfg_width = 2'd1;
      offer(p);
      check("R3 565", out_data, 24'h00AAEF);
      cfg_width = 2'd2;
      offer(p);
      check("R4 8 lines", out_data, 24'h00007E);
      @(negedge clk);
      check("R8 idle de", 24'(out_de), 24'd0);
   endtask

   task automatic t_roundtrip;
      cfg_tdm_en = 1'b0;
      cfg_width = 2'd1;
      for (int i = 0; i < 6; i++) begin
         logic [15:0] w;
         logic [4:0] r5, b5;
         logic [5:0] g6;
         w = 16'h1234 * 16'(i + 3) ^ 16'hC5A9;
         r5 = w[15:11]; g6 = w[10:5]; b5 = w[4:0];
         offer(mkpix({r5, r5, r5[4:3]}, {g6, g6}, {b5, b5, b5[4:3]}));
         check("R3 roundtrip", out_data, {8'h00, w});
      end
   endtask

   task automatic t_tdm_bytes;
      logic [47:0] p;
      p = mkpix(12'h9A3, 12'h47F, 12'hE20);
      cfg_tdm_en = 1'b1; cfg_width = 2'd2; cfg_cyc_code = 2'd2;
      cfg_slot_bits = bits3(8, 8, 8);
      offer(p);
      check("R5 beat1 R", out_data, 24'h00009A);
      check("R7 ready low b1", 24'(in_ready), 24'd0);
      cfg_width = 2'd0; cfg_tdm_en = 1'b0; cfg_slot_bits = bits3(3, 3, 3);
      @(negedge clk);
      check("R9 beat2 G", out_data, 24'h000047);
      check("R7 ready low b2", 24'(in_ready), 24'd0);
      @(negedge clk);
      check("R9 beat3 B", out_data, 24'h0000E2);
      check("R7 ready high last", 24'(in_ready), 24'd1);
      check("R8 de last", 24'(out_de), 24'd1);
      @(negedge clk);
      check("R8 de after", 24'(out_de), 24'd0);
   endtask

   task automatic t_tdm_uneven;
      logic [47:0] p;
      logic [23:0] w;
      p = mkpix(12'h3C5, 12'hB61, 12'h2F0);
      w = word888(p);
      cfg_tdm_en = 1'b1; cfg_width = 2'd1; cfg_cyc_code = 2'd1;
      cfg_slot_bits = bits3(12, 12, 8);
      offer(p);
      check("R5 two beat 1", out_data, 24'(w[23:12]));
      @(negedge clk);
      check("R5 two beat 2", out_data, 24'(w[11:0]));
      check("R7 ready last of 2", 24'(in_ready), 24'd1);
      cfg_width = 2'd0; cfg_cyc_code = 2'd3;
      cfg_slot_bits = bits3(4, 0, 30);
      offer(p);
      check("R5 4 bits", out_data, 24'(w[23:20]));
      @(negedge clk);
      check("R5 zero count", out_data, 24'h0);
      @(negedge clk);
      check("R6 clamp", out_data, {w[19:0], 4'h0});
      cfg_width = 2'd2; cfg_cyc_code = 2'd0;
      cfg_slot_bits = bits3(16, 8, 8);
      offer(p);
      check("R6 mask", out_data, {16'h0, w[15:8]});
      check("R5 single beat ready", 24'(in_ready), 24'd1);
   endtask

   task automatic t_backtoback;
      logic [47:0] p1, p2;
      p1 = mkpix(12'h112, 12'h223, 12'h334);
      p2 = mkpix(12'hA55, 12'hB66, 12'hC77);
      cfg_tdm_en = 1'b1; cfg_width = 2'd2; cfg_cyc_code = 2'd2;
      cfg_slot_bits = bits3(8, 8, 8);
      @(negedge clk);
      in_pixel = p1; in_valid = 1'b1;
      @(negedge clk);
      in_pixel = p2;
      check("R10 p1 R", out_data, 24'h11);
      @(negedge clk);
      check("R7 stall G", out_data, 24'h22);
      @(negedge clk);
      check("R7 stall B", out_data, 24'h33);
      @(negedge clk);
      in_valid = 1'b0;
      check("R10 p2 R", out_data, 24'hA5);
      check("R10 de", 24'(out_de), 24'd1);
      @(negedge clk);
      check("R10 p2 G", out_data, 24'hB6);
      @(negedge clk);
      check("R10 p2 B", out_data, 24'hC7);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_roundtrip();
      t_tdm_bytes();
      t_tdm_uneven();
      t_backtoback();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule